// File: doc/BRIEF.md
# Interrupt Request Controller

This block gathers one-cycle event pulses from seven on-chip sources (three timers, an external pin, a serial port, a comparator and a port pin) into sticky request flags. A single global enable bit decides whether any pending flag may be dispatched. While it is set and at least one flag is pending, the controller raises one request line towards the CPU. It also reports the index of the winning source, using a fixed lowest-index-first order.

Servicing a request is one-shot. When the CPU acknowledges, the controller drops the global enable and clears only the flag of the source it serviced. Every other pending flag stays latched. Software re-arms dispatch by writing the enable register or by pulsing the return-from-interrupt strobe. It removes stale flags with a two-cycle clear command that carries an 8-bit mask.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, no flag is pending and `irq_req` is 0.
- R2: A write to address 0x34 loads bit 0 of `reg_wdata` into the global enable. Bits 3..1 of `reg_rdata` always read 0. Writes to any other address leave the enable unchanged.
- R3: An event pulse on `src_evt[i]` sets flag i whatever the enable state. While the enable is 0, `irq_req` stays 0 and the flags are held.
- R4: `irq_req` is 1 exactly when the enable is 1 and some flag is set. `irq_idx` gives the lowest set flag index: 0 timer 0, 1 timer 2, 2 timer 3, 3 external pin, 4 serial port, 5 comparator, 6 port pin.
- R5: An `ack` while `irq_req` is 1 clears the enable and the flag at `irq_idx` at that clock edge. All other flags keep their state.
- R6: A `reti` pulse sets the enable to 1. In one cycle, an accepted acknowledge beats both a write and `reti`, and a write to 0x34 beats `reti`.
- R7: `clr_start` with `clr_mask` in cycle N clears every flag i whose mask bit i is 1, at the clock edge that ends cycle N+1. Mask bit 7 and zero bits change nothing.
- R8: An event on a source in the same cycle that its flag is removed by a mask clear or an acknowledge leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 7 | One-cycle event pulse per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Current enable register contents |
| clr_start | input | 1 | First cycle of a mask clear command |
| clr_mask | input | 8 | Clear mask, sampled with `clr_start` |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | input | 1 | CPU acknowledge of the current request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 3 | Index of the selected source |

## Verification
The bench builds the block with its default parameters: seven sources, an 8-bit clear mask, a 4-bit enable register at address 0x34 and a 3-bit index. With these values every source position, the reserved mask bit 7 and the reserved register bits can all be reached. The bench watches the flags only through `irq_req` and `irq_idx`, so each case arms the enable before it inspects pending state. It confirms the two-edge latency of the mask clear one edge at a time. Collisions are driven directly: an event during the clear's apply edge, an event during an acknowledge, and an acknowledge together with `reti`.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned SRC_CNT    = 7;
    localparam int unsigned CLR_MASK_W = 8;
    localparam int unsigned EN_REG_W   = 4;
    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned EN_ADDR    = 'h34;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned REG_W = irq_pkg::EN_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             reti,
    input  logic             take,
    output logic [REG_W-1:0] value
);
    localparam logic [REG_W-1:0] LIVE_BITS = REG_W'(1);

    typedef struct packed {
        logic [REG_W-1:0] val;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.val = '0;
        end else if (wr_hit) begin
            st_d.val = wdata & LIVE_BITS;
        end else if (reti) begin
            st_d.val = LIVE_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned NS     = irq_pkg::SRC_CNT,
    parameter int unsigned MASK_W = irq_pkg::CLR_MASK_W,
    localparam int unsigned IDX_W = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS-1:0]     evt,
    input  logic              clr_start,
    input  logic [MASK_W-1:0] clr_mask,
    input  logic              take,
    input  logic [IDX_W-1:0]  take_idx,
    output logic [NS-1:0]     flags,
    output logic              clr_pend
);
    typedef struct packed {
        logic [NS-1:0] flags;
        logic          pend;
        logic [NS-1:0] mask;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [NS-1:0] take_vec;
    logic          unused_mask_bits;

    for (genvar g = 0; g < NS; g++) begin : g_take
        assign take_vec[g] = take && (take_idx == IDX_W'(g));
    end

    if (MASK_W > NS) begin : g_rsvd
        assign unused_mask_bits = &{1'b0, clr_mask[MASK_W-1:NS]};
    end else begin : g_norsvd
        assign unused_mask_bits = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            st_d.flags = st_d.flags & ~st_q.mask;
        end
        st_d.flags = (st_d.flags & ~take_vec) | evt;
        st_d.pend  = clr_start;
        st_d.mask  = clr_start ? clr_mask[NS-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags    = st_q.flags;
    assign clr_pend = st_q.pend;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NS = irq_pkg::SRC_CNT,
    localparam int unsigned IDX_W = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [NS-1:0]    flags,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (flags[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |flags;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int unsigned NS     = irq_pkg::SRC_CNT,
    parameter int unsigned MASK_W = irq_pkg::CLR_MASK_W,
    parameter int unsigned REG_W  = irq_pkg::EN_REG_W,
    parameter int unsigned ADDR_W = irq_pkg::REG_ADDR_W,
    parameter int unsigned EN_ADDR = irq_pkg::EN_ADDR,
    localparam int unsigned IDX_W = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS-1:0]     src_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              clr_start,
    input  logic [MASK_W-1:0] clr_mask,
    input  logic              reti,
    input  logic              ack,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_idx
);
    logic [NS-1:0]    flags;
    logic             clr_pend;
    logic             any_pend;
    logic             take;
    logic             wr_hit;
    logic [REG_W-1:0] en_val;

    assign wr_hit = reg_wr && (reg_addr == ADDR_W'(EN_ADDR));
    assign take   = ack && irq_req;

    irq_enable_reg #(.REG_W(REG_W)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (reg_wdata),
        .reti   (reti),
        .take   (take),
        .value  (en_val)
    );

    irq_flag_bank #(.NS(NS), .MASK_W(MASK_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (src_evt),
        .clr_start (clr_start),
        .clr_mask  (clr_mask),
        .take      (take),
        .take_idx  (irq_idx),
        .flags     (flags),
        .clr_pend  (clr_pend)
    );

    irq_prio_enc #(.NS(NS)) u_prio (
        .flags (flags),
        .any   (any_pend),
        .idx   (irq_idx)
    );

    assign irq_req   = en_val[0] && any_pend;
    assign reg_rdata = en_val;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int unsigned NS    = 7,
    parameter int unsigned REG_W = 4,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NS-1:0]    src_evt,
    input logic             ack,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_idx,
    input logic [REG_W-1:0] reg_rdata,
    input logic [NS-1:0]    flags,
    input logic             clr_pend
);
    assert_req_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> reg_rdata[0]);

    assert_idx_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flags[irq_idx] &&
                     ((flags & ((NS'(1) << irq_idx) - NS'(1))) == '0)));

    assert_take_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> (reg_rdata == '0));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:1] == '0);

    assert_evt_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((flags & $past(src_evt)) == $past(src_evt)));

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack && irq_req) && !clr_pend) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NS(NS), .REG_W(REG_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .ack       (ack),
    .irq_req   (irq_req),
    .irq_idx   (irq_idx),
    .reg_rdata (reg_rdata),
    .flags     (flags),
    .clr_pend  (clr_pend)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_evt = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       clr_start = 1'b0;
    logic [7:0] clr_mask = '0;
    logic       reti = 1'b0;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [2:0] irq_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_start(clr_start), .clr_mask(clr_mask), .reti(reti), .ack(ack),
        .irq_req(irq_req), .irq_idx(irq_idx)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        src_evt = '0; reg_wr = 0; clr_start = 0; clr_mask = '0; reti = 0; ack = 0;
    endtask

    task automatic wr_en(logic [7:0] a, logic [3:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic clear_all();
        clr_start = 1; clr_mask = 8'h7F; tick(); tick();
        wr_en(8'h34, 4'h0);
    endtask

    task automatic t_reset();
        chk("R1 enable", reg_rdata, 0);
        chk("R1 req", irq_req, 0);
    endtask

    task automatic t_enable_reg();
        wr_en(8'h34, 4'hF);
        chk("R2 write ones", reg_rdata, 1);
        wr_en(8'h35, 4'h0);
        chk("R2 other addr", reg_rdata, 1);
        wr_en(8'h34, 4'h0);
        chk("R2 write zero", reg_rdata, 0);
    endtask

    task automatic t_latch_disabled();
        src_evt = 7'b010_1000; tick();
        tick();
        chk("R3 no req when disabled", irq_req, 0);
        wr_en(8'h34, 4'h1);
        chk("R3 held flag req", irq_req, 1);
        chk("R4 lowest idx", irq_idx, 3);
    endtask

    task automatic t_ack();
        ack = 1; tick();
        chk("R5 enable cleared", reg_rdata, 0);
        chk("R5 req dropped", irq_req, 0);
        reti = 1; tick();
        chk("R6 reti enables", reg_rdata, 1);
        chk("R5 other flag kept", irq_req, 1);
        chk("R5 next idx", irq_idx, 5);
        ack = 1; tick();
        reti = 1; tick();
        chk("R5 all serviced", irq_req, 0);
        wr_en(8'h34, 4'h0);
    endtask

    task automatic t_priority();
        src_evt = 7'b100_0010; tick();
        wr_en(8'h34, 4'h1);
        chk("R4 idx 1 over 6", irq_idx, 1);
        ack = 1; tick();
        reti = 1; tick();
        chk("R4 idx 6 next", irq_idx, 6);
        ack = 1; tick();
        reti = 1; tick();
        chk("R4 none left", irq_req, 0);
        wr_en(8'h34, 4'h0);
    endtask

    task automatic t_clear();
        wr_en(8'h34, 4'h1);
        src_evt = 7'b001_0101; tick();
        chk("R4 idx 0", irq_idx, 0);
        clr_start = 1; clr_mask = 8'h85; tick();
        chk("R7 not yet applied", irq_idx, 0);
        tick();
        chk("R7 applied idx", irq_idx, 4);
        chk("R7 bit4 kept", irq_req, 1);
        clr_start = 1; clr_mask = 8'h10; tick(); tick();
        chk("R7 cleared last", irq_req, 0);
        wr_en(8'h34, 4'h0);
    endtask

    task automatic t_collide();
        wr_en(8'h34, 4'h1);
        src_evt = 7'b000_0100; tick();
        clr_start = 1; clr_mask = 8'h04; tick();
        src_evt = 7'b000_0100; tick();
        chk("R8 event beats clear", irq_req, 1);
        chk("R8 idx", irq_idx, 2);
        ack = 1; src_evt = 7'b000_0100; tick();
        chk("R5 ack disables", reg_rdata, 0);
        reti = 1; tick();
        chk("R8 event beats ack", irq_req, 1);
        chk("R8 idx after ack", irq_idx, 2);
        ack = 1; reti = 1; tick();
        chk("R6 ack beats reti", reg_rdata, 0);
        reti = 1; reg_wr = 1; reg_addr = 8'h34; reg_wdata = 4'h0; tick();
        chk("R6 write beats reti", reg_rdata, 0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_enable_reg();
        t_latch_disabled();
        t_ack();
        t_priority();
        t_clear();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule